// File: doc/BRIEF.md
# Banked Stack Pointer Register Unit

This unit keeps two physical stack pointers, a main copy and a process copy, and shows them to the rest of the core as one architectural stack pointer. Which copy answers to the architectural name is decided by a stack-select control bit held inside the unit, together with the current execution mode. In handler mode the main copy is always used. In thread mode the control bit picks the main copy when it is 0 and the process copy when it is 1. A single register-file style port, with a read enable, a write enable and a two-bit selector, reaches the architectural pointer, either copy by its own name, or the control bit.

Access rules follow the privilege input. The main copy, named directly, and writes of the control bit need privileged level. A refused access raises a fault flag in the same cycle and changes nothing. After reset the unit fetches the main pointer's starting value over a small memory read port. It reports busy until that value is loaded, and it ignores the access port while busy.

Top module: `sp_bank_unit`

## Requirements
- R1: After reset the control bit is 0, `boot_busy` is 1, and `mem_req` is 1 with `mem_addr` equal to BOOT_ADDR (default 0x0000_0000).
- R2: `mem_req` stays high until a cycle with `mem_rvalid`=1. `mem_rdata` is captured at that edge and `mem_req` drops. The main pointer is written at the following edge, with bits [1:0] cleared, and `boot_busy` falls at that same edge.
- R3: While `boot_busy` is 1, accesses are ignored: `rd_data` is 0, `acc_fault` is 0, and no register changes.
- R4: The selector encoding is 0=architectural SP, 1=main, 2=process, 3=control bit. In thread mode (`handler_mode`=0) with the control bit 0, selector 0 reaches the main pointer.
- R5: In thread mode with the control bit 1, selector 0 reaches the process pointer.
- R6: In handler mode (`handler_mode`=1), selector 0 reaches the main pointer whatever the control bit holds.
- R7: Reading or writing selector 1 with `priv`=0 sets `acc_fault` in that cycle, returns `rd_data`=0 and leaves the main pointer unchanged. Selector 0 is allowed at either level.
- R8: The process pointer (selector 2) can be read and written with `priv` either 0 or 1, and no fault is raised.
- R9: Every write to either pointer stores the write data with bits [1:0] forced to 0.
- R10: The control bit is written from `wr_data[0]` and reads back in `rd_data[0]` (upper bits 0). Reading it is allowed at either level. Writing it with `priv`=0 faults and leaves it unchanged. A new value steers selector 0 from the next cycle.
- R11: A read and a write of the same register in one cycle return the old value. The new value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| handler_mode | input | 1 | 1 = handler mode, 0 = thread mode |
| priv | input | 1 | 1 = privileged access |
| acc_sel | input | 2 | Access target: 0 SP, 1 main, 2 process, 3 control |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W (32) | Write data |
| rd_data | output | DATA_W (32) | Read data, valid in the request cycle |
| acc_fault | output | 1 | Access refused by privilege rules |
| boot_busy | output | 1 | Reset fetch in progress |
| mem_req | output | 1 | Boot fetch read request |
| mem_addr | output | ADDR_W (32) | Boot fetch address |
| mem_rvalid | input | 1 | Boot fetch data strobe |
| mem_rdata | input | DATA_W (32) | Boot fetch data |

## Verification
The assertions take for granted that `mem_rvalid` pulses only while `mem_req` is high and never arrives again once the boot load is done. They also assume that the mode, privilege and access inputs are stable, defined levels at each clock edge. The bench returns the boot word once, one cycle after several cycles of waiting, and then drops the strobe for good. It drives every input on the falling edge, so every property sees settled values.

// File: rtl/sp_bank_pkg.sv
package sp_bank_pkg;

   typedef enum logic [1:0] {
      SEL_SP   = 2'd0,
      SEL_MAIN = 2'd1,
      SEL_PROC = 2'd2,
      SEL_CTRL = 2'd3
   } sp_sel_e;

   typedef enum logic [1:0] {
      BOOT_REQ  = 2'd0,
      BOOT_LOAD = 2'd1,
      BOOT_DONE = 2'd2
   } boot_st_e;

   typedef struct packed {
      logic main_we;
      logic proc_we;
      logic ctl_we;
      logic fault;
      logic rd_ok;
      logic pick_main;
      logic pick_proc;
      logic pick_ctl;
   } sp_grant_t;

endpackage

// File: rtl/sp_boot_fetch.sv
module sp_boot_fetch
   import sp_bank_pkg::*;
#(
   parameter int unsigned          DATA_W    = 32,
   parameter int unsigned          ADDR_W    = 32,
   parameter logic [ADDR_W-1:0]    BOOT_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              busy,
   output logic              load_we,
   output logic [DATA_W-1:0] load_data
);

   boot_st_e          st_q;
   logic [DATA_W-1:0] hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= BOOT_REQ;
         hold_q <= '0;
      end else begin
         unique case (st_q)
            BOOT_REQ: begin
               if (mem_rvalid) begin
                  hold_q <= mem_rdata;
                  st_q   <= BOOT_LOAD;
               end
            end
            BOOT_LOAD: st_q <= BOOT_DONE;
            default:   st_q <= BOOT_DONE;
         endcase
      end
   end

   assign mem_req   = (st_q == BOOT_REQ);
   assign mem_addr  = BOOT_ADDR;
   assign busy      = (st_q != BOOT_DONE);
   assign load_we   = (st_q == BOOT_LOAD);
   assign load_data = hold_q;

   // R2: the request stays up until data returns
   p_req_held_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rvalid) |=> mem_req);

   // R2: the load happens once and ends the busy phase
   p_load_once_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      load_we |=> (!busy && !load_we));

endmodule

// File: rtl/sp_access_guard.sv
module sp_access_guard
   import sp_bank_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      busy,
   input  logic      handler_mode,
   input  logic      priv,
   input  logic      ctl,
   input  logic [1:0] acc_sel,
   input  logic      rd_en,
   input  logic      wr_en,
   output sp_grant_t grant
);

   logic active_proc;
   logic tgt_main;
   logic tgt_proc;
   logic tgt_ctl;
   logic need_priv;
   logic live;

   assign active_proc = !handler_mode && ctl;
   assign live        = (rd_en || wr_en) && !busy;

   always_comb begin
      tgt_main  = 1'b0;
      tgt_proc  = 1'b0;
      tgt_ctl   = 1'b0;
      need_priv = 1'b0;
      unique case (sp_sel_e'(acc_sel))
         SEL_SP: begin
            tgt_main = !active_proc;
            tgt_proc = active_proc;
         end
         SEL_MAIN: begin
            tgt_main  = 1'b1;
            need_priv = 1'b1;
         end
         SEL_PROC: tgt_proc = 1'b1;
         default: begin
            tgt_ctl   = 1'b1;
            need_priv = wr_en;
         end
      endcase
   end

   always_comb begin
      grant.fault     = live && need_priv && !priv;
      grant.main_we   = wr_en && !busy && !grant.fault && tgt_main;
      grant.proc_we   = wr_en && !busy && !grant.fault && tgt_proc;
      grant.ctl_we    = wr_en && !busy && !grant.fault && tgt_ctl;
      grant.rd_ok     = rd_en && !busy && !grant.fault;
      grant.pick_main = tgt_main;
      grant.pick_proc = tgt_proc;
      grant.pick_ctl  = tgt_ctl;
   end

   // R3: nothing is granted while the boot fetch runs
   p_busy_no_grant_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !(grant.main_we || grant.proc_we || grant.ctl_we || grant.rd_ok));

   // R6: in handler mode the architectural name never reaches the process copy
   p_handler_main_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (handler_mode && acc_sel == 2'd0) |-> !grant.proc_we);

endmodule

// File: rtl/sp_bank_regs.sv
module sp_bank_regs #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ALIGN_BITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              main_we,
   input  logic              proc_we,
   input  logic              load_we,
   input  logic [DATA_W-1:0] load_data,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] main_q,
   output logic [DATA_W-1:0] proc_q
);

   logic [DATA_W-1:0] wr_al;
   logic [DATA_W-1:0] load_al;

   generate
      if (ALIGN_BITS == 0) begin : g_no_align
         assign wr_al   = wr_data;
         assign load_al = load_data;
      end else begin : g_align
         localparam logic [DATA_W-1:0] KEEP_MASK = {{(DATA_W-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};
         assign wr_al   = wr_data & KEEP_MASK;
         assign load_al = load_data & KEEP_MASK;

         // R9: both copies always hold aligned values
         p_aligned_r9 : assert property (@(posedge clk) disable iff (!rst_n)
            (main_q[ALIGN_BITS-1:0] == '0) && (proc_q[ALIGN_BITS-1:0] == '0));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         main_q <= '0;
         proc_q <= '0;
      end else begin
         if (load_we) begin
            main_q <= load_al;
         end else if (main_we) begin
            main_q <= wr_al;
         end
         if (proc_we) begin
            proc_q <= wr_al;
         end
      end
   end

   // R3: the boot load never meets a port write
   p_load_excl_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      load_we |-> !(main_we || proc_we));

   // R11: a written copy shows the new value at the next edge
   p_proc_update_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      proc_we |=> (proc_q == $past(wr_al)));

endmodule

// File: rtl/sp_bank_unit.sv
module sp_bank_unit
   import sp_bank_pkg::*;
#(
   parameter int unsigned          DATA_W     = 32,
   parameter int unsigned          ADDR_W     = 32,
   parameter int unsigned          ALIGN_BITS = 2,
   parameter logic [ADDR_W-1:0]    BOOT_ADDR  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              handler_mode,
   input  logic              priv,
   input  logic [1:0]        acc_sel,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              acc_fault,
   output logic              boot_busy,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata
);

   localparam int unsigned CTL_PAD = DATA_W - 1;

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("sp_bank_unit: DATA_W must be at least 8");
      end
      if (ALIGN_BITS >= DATA_W) begin : g_bad_align
         $error("sp_bank_unit: ALIGN_BITS must be below DATA_W");
      end
   endgenerate

   sp_grant_t         grant;
   logic              ctl_q;
   logic              load_we;
   logic [DATA_W-1:0] load_data;
   logic [DATA_W-1:0] main_q;
   logic [DATA_W-1:0] proc_q;

   sp_boot_fetch #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .BOOT_ADDR(BOOT_ADDR)
   ) u_boot (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_rvalid(mem_rvalid),
      .mem_rdata (mem_rdata),
      .mem_req   (mem_req),
      .mem_addr  (mem_addr),
      .busy      (boot_busy),
      .load_we   (load_we),
      .load_data (load_data)
   );

   sp_access_guard u_guard (
      .clk         (clk),
      .rst_n       (rst_n),
      .busy        (boot_busy),
      .handler_mode(handler_mode),
      .priv        (priv),
      .ctl         (ctl_q),
      .acc_sel     (acc_sel),
      .rd_en       (rd_en),
      .wr_en       (wr_en),
      .grant       (grant)
   );

   sp_bank_regs #(
      .DATA_W    (DATA_W),
      .ALIGN_BITS(ALIGN_BITS)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .main_we  (grant.main_we),
      .proc_we  (grant.proc_we),
      .load_we  (load_we),
      .load_data(load_data),
      .wr_data  (wr_data),
      .main_q   (main_q),
      .proc_q   (proc_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q <= 1'b0;
      end else if (grant.ctl_we) begin
         ctl_q <= wr_data[0];
      end
   end

   always_comb begin
      rd_data = '0;
      if (grant.rd_ok) begin
         if (grant.pick_main) begin
            rd_data = main_q;
         end else if (grant.pick_proc) begin
            rd_data = proc_q;
         end else if (grant.pick_ctl) begin
            rd_data = {{CTL_PAD{1'b0}}, ctl_q};
         end
      end
   end

   assign acc_fault = grant.fault;

   // R3: the port stays silent during the boot fetch
   p_busy_quiet_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      boot_busy |-> (!acc_fault && rd_data == '0));

   // R7: a refused write leaves the main copy as it was
   p_main_keep_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (acc_fault && wr_en && !boot_busy) |=> $stable(main_q));

   // R10: an unprivileged request never moves the control bit
   p_ctl_priv_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !priv) |=> $stable(ctl_q));

   // R6: the architectural read in handler mode returns the main copy
   p_handler_read_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (!boot_busy && handler_mode && rd_en && acc_sel == 2'd0) |-> (rd_data == main_q));

   // R1: the control bit leaves reset cleared while the fetch is pending
   p_reset_ctl_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !ctl_q);

endmodule

// File: tb/sp_bank_unit_bench.sv
module sp_bank_unit_bench;

   localparam int W = 32;

   typedef struct packed {
      logic        hm;
      logic        pv;
      logic [1:0]  sel;
      logic        rd;
      logic        wr;
      logic [31:0] data;
      logic [31:0] exp_rd;
      logic        exp_fault;
      logic [3:0]  req;
   } vec_t;

   // Encoding: sel 0 SP, 1 main, 2 process, 3 control.
   // Start state after boot: main=2000_0FFC, process=0, control=0.
   localparam int NV = 21;
   localparam vec_t VEC [NV] = '{
      '{1'b0,1'b1,2'd2,1'b1,1'b0,32'h0,        32'h0,        1'b0,4'd3 },  // R3 busy-time write to process was dropped
      '{1'b0,1'b1,2'd0,1'b1,1'b0,32'h0,        32'h2000_0FFC,1'b0,4'd4 },  // R4 thread, ctl 0 -> main
      '{1'b0,1'b0,2'd2,1'b0,1'b1,32'h1000_0003,32'h0,        1'b0,4'd8 },  // R8 unpriv process write
      '{1'b0,1'b0,2'd2,1'b1,1'b0,32'h0,        32'h1000_0000,1'b0,4'd9 },  // R9 low bits cleared
      '{1'b0,1'b0,2'd1,1'b1,1'b0,32'h0,        32'h0,        1'b1,4'd7 },  // R7 unpriv main read faults
      '{1'b0,1'b0,2'd1,1'b0,1'b1,32'h1234_5678,32'h0,        1'b1,4'd7 },  // R7 unpriv main write faults
      '{1'b0,1'b1,2'd1,1'b1,1'b0,32'h0,        32'h2000_0FFC,1'b0,4'd7 },  // R7 main unchanged
      '{1'b0,1'b0,2'd3,1'b0,1'b1,32'h1,        32'h0,        1'b1,4'd10},  // R10 unpriv control write
      '{1'b0,1'b0,2'd3,1'b1,1'b0,32'h0,        32'h0,        1'b0,4'd10},  // R10 control still 0, read ok
      '{1'b0,1'b1,2'd3,1'b1,1'b1,32'h1,        32'h0,        1'b0,4'd11},  // R11 read old control with write
      '{1'b0,1'b1,2'd3,1'b1,1'b0,32'h0,        32'h1,        1'b0,4'd10},  // R10 control now 1
      '{1'b0,1'b0,2'd0,1'b1,1'b0,32'h0,        32'h1000_0000,1'b0,4'd5 },  // R5 thread, ctl 1 -> process
      '{1'b1,1'b1,2'd0,1'b1,1'b0,32'h0,        32'h2000_0FFC,1'b0,4'd6 },  // R6 handler -> main
      '{1'b1,1'b1,2'd0,1'b1,1'b1,32'h3000_0001,32'h2000_0FFC,1'b0,4'd11},  // R11 old main returned
      '{1'b1,1'b1,2'd1,1'b1,1'b0,32'h0,        32'h3000_0000,1'b0,4'd11},  // R11 new main visible
      '{1'b0,1'b0,2'd0,1'b1,1'b1,32'h4000_0006,32'h1000_0000,1'b0,4'd11},  // R11 old process returned
      '{1'b0,1'b1,2'd2,1'b1,1'b0,32'h0,        32'h4000_0004,1'b0,4'd9 },  // R9 process aligned
      '{1'b0,1'b1,2'd1,1'b0,1'b1,32'h5000_0002,32'h0,        1'b0,4'd9 },  // R9 main write
      '{1'b0,1'b1,2'd1,1'b1,1'b0,32'h0,        32'h5000_0000,1'b0,4'd9 },  // R9 main aligned
      '{1'b0,1'b1,2'd3,1'b0,1'b1,32'h0,        32'h0,        1'b0,4'd10},  // R10 clear control
      '{1'b0,1'b0,2'd0,1'b1,1'b0,32'h0,        32'h5000_0000,1'b0,4'd4 }   // R4 back to main
   };

   logic          clk = 1'b0;
   logic          rst_n;
   logic          handler_mode, priv, rd_en, wr_en, mem_rvalid;
   logic [1:0]    acc_sel;
   logic [W-1:0]  wr_data, rd_data, mem_rdata, mem_addr;
   logic          acc_fault, boot_busy, mem_req;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   sp_bank_unit u_sp_bank_unit (
      .clk(clk), .rst_n(rst_n), .handler_mode(handler_mode), .priv(priv),
      .acc_sel(acc_sel), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .acc_fault(acc_fault), .boot_busy(boot_busy),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic hm, input logic pv, input logic [1:0] sel,
                        input logic rd, input logic wr, input logic [31:0] d);
      @(negedge clk);
      handler_mode = hm; priv = pv; acc_sel = sel; rd_en = rd; wr_en = wr; wr_data = d;
      #3;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; handler_mode = 1'b0; priv = 1'b0; acc_sel = 2'd0;
      rd_en = 1'b0; wr_en = 1'b0; wr_data = '0; mem_rvalid = 1'b0; mem_rdata = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #3;
      // R1 reset state
      chk("R1 busy", {31'b0, boot_busy}, 32'd1);
      chk("R1 mem_req", {31'b0, mem_req}, 32'd1);
      chk("R1 mem_addr", mem_addr, 32'h0);

      // R3 accesses during the fetch are ignored
      drive(1'b0, 1'b1, 2'd1, 1'b1, 1'b0, 32'h0);
      chk("R3 rd_data busy", rd_data, 32'h0);
      drive(1'b0, 1'b0, 2'd1, 1'b1, 1'b1, 32'h0BAD_0000);
      chk("R3 fault busy", {31'b0, acc_fault}, 32'd0);
      drive(1'b0, 1'b1, 2'd2, 1'b0, 1'b1, 32'h7777_7770);
      drive(1'b0, 1'b1, 2'd3, 1'b0, 1'b1, 32'h1);
      chk("R2 mem_req held", {31'b0, mem_req}, 32'd1);
      drive(1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0);

      // R2 boot data return
      @(negedge clk);
      mem_rvalid = 1'b1; mem_rdata = 32'h2000_0FFF;
      #3;
      chk("R2 busy at strobe", {31'b0, boot_busy}, 32'd1);
      @(negedge clk);
      mem_rvalid = 1'b0; mem_rdata = 32'hDEAD_BEEF;
      #3;
      chk("R2 busy during load", {31'b0, boot_busy}, 32'd1);
      chk("R2 mem_req dropped", {31'b0, mem_req}, 32'd0);
      @(negedge clk);
      #3;
      chk("R2 busy done", {31'b0, boot_busy}, 32'd0);

      // Vector table
      for (int i = 0; i < NV; i++) begin
         drive(VEC[i].hm, VEC[i].pv, VEC[i].sel, VEC[i].rd, VEC[i].wr, VEC[i].data);
         chk($sformatf("R%0d vec %0d rd_data", VEC[i].req, i), rd_data, VEC[i].exp_rd);
         chk($sformatf("R%0d vec %0d fault", VEC[i].req, i), {31'b0, acc_fault}, {31'b0, VEC[i].exp_fault});
      end

      // R10 control change steers SP from the very next cycle
      drive(1'b0, 1'b1, 2'd3, 1'b0, 1'b1, 32'h1);
      drive(1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 32'h0);
      chk("R10 next-cycle select", rd_data, 32'h4000_0004);
      // R6 handler ignores control bit set
      drive(1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 32'h0);
      chk("R6 handler unpriv SP", rd_data, 32'h5000_0000);
      chk("R7 SP name no fault", {31'b0, acc_fault}, 32'd0);
      drive(1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

endmodule